// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block fills a set of shadow configuration bytes from a serial EEPROM that answers the three-wire READ command (select, clock, data to the device, data from the device). A load fetches 36 bytes as 18 sixteen-bit words and sums every byte. The loaded bytes are kept only when the sum matches a fixed target. Otherwise, or when no device answers, every shadow byte falls back to a computed default and the block waits for software to configure it.

A load starts in two ways. One is by itself once hardware reset ends, when a detect strap sampled during reset says a device is fitted. The other is when the host sets the load-request bit while the stop input is high. The host sees a single 16-bit control/status word. Host accesses are dropped, and get no acknowledge, while the request bit is one. With the pin-enable bit set and no load running, four software bits drive the serial pins and the busy pin directly. With pin-enable clear, the busy pin shows the inverted valid flag.

The load controller has six states. ST_BOOT goes to ST_START when the strap was high, else to ST_IDLE. ST_IDLE goes to ST_START once the request bit is set. ST_START issues one word read and goes to ST_WAIT. ST_WAIT goes back to ST_START after a good word that is not the last one, to ST_DONE after the last word, and to ST_FAIL when the device is absent. ST_DONE and ST_FAIL both return to ST_IDLE. The serial engine has three states. E_IDLE goes to E_SHIFT on a start. E_SHIFT goes to E_GAP after the last data bit, or early when the dummy bit reads high. E_GAP waits one bit period with select low, then pulses done and returns to E_IDLE.

Top module: `eecfg_loader`

## Requirements
- R1: Each word read asserts ee_cs for one frame. The frame sends a 1, then 1, then 0, then the 6-bit word address MSB first, with ee_di changing only while ee_sk is low. A load reads word addresses 0 to 17 in ascending order. After the address, the device's low dummy bit is expected, then 16 data bits MSB first, sampled at ee_sk rising. Word w gives byte 2w from its high half and byte 2w+1 from its low half, and byte i is cfg_data[8i+7:8i].
- R2: While the load-request bit is one, host reads and writes get no hst_ack and change no register.
- R3: The load-request bit (status bit 14) returns to zero by itself when a load ends, whatever the outcome.
- R4: The valid flag (status bit 15) becomes 1 only when all 18 words arrived and the 8-bit sum of the 36 bytes equals CSUM (default 0xFF). cfg_data then holds the loaded bytes and swcfg_wait is 0.
- R5: When the sum does not match, the valid flag is 0 and every byte i of cfg_data equals (7*i+3) mod 256.
- R6: When the dummy bit reads high, the load stops after that first frame, with no second ee_cs assertion. The valid flag is 0, every shadow byte returns to its default, and swcfg_wait becomes 1.
- R7: det_strap is sampled in the last reset cycle into status bit 13. Later changes of the pin do not alter it.
- R8: After reset, a load runs by itself only if the sampled strap is 1. With the strap at 0, no frame is sent, the valid flag stays 0 and swcfg_wait is 1.
- R9: Writing 1 to bit 14 starts a load only when stop is 1, and that load is attempted whatever the strap value.
- R10: With pin-enable (bit 4) set and no load running, ee_cs, ee_sk, ee_di and busy_o follow written bits 2, 1, 0 and 3.
- R11: With pin-enable clear and no load running, busy_o is the inverse of the valid flag and ee_cs, ee_sk and ee_di are 0.
- R12: A status read returns {valid, request, strap, 8 zero bits, pin-enable, bits 3..0 as written}. Writes to bits 15, 13 and 12..5 have no effect.
- R13: After reset with the strap at 0, the status reads 0x0000 and cfg_data holds the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| det_strap | input | 1 | Device-present strap, sampled during reset |
| stop | input | 1 | Stop state; permits setting the load request |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Status word captured by an accepted read |
| hst_ack | output | 1 | Access accepted (one cycle after the strobe) |
| ee_cs | output | 1 | Serial device select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Data to the device |
| ee_do | input | 1 | Data from the device (high when nothing answers) |
| busy_o | output | 1 | Busy pin: software bit or inverted valid flag |
| swcfg_wait | output | 1 | Waiting for software configuration |
| cfg_data | output | 288 | Shadow configuration bytes |

## Verification
The bench builds the block with SK_HALF=1, so each half of a serial clock period is one system clock. A full 36-byte load then takes about a thousand cycles, and two dozen loads fit easily, including random contents, checksum hits and misses, absent devices and strap-driven boot loads. N_BYTES, AW and CSUM keep their defaults, so the 18-word address walk and the 0xFF target are the values actually exercised. A device model behind the pins records every frame, so the command bits, the address order and the single truncated frame of an absent device are all visible at the ports.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } ld_state_t;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SHIFT,
        E_GAP
    } mw_state_t;

    localparam int RB_VALID = 15;
    localparam int RB_REQ   = 14;
    localparam int RB_DET   = 13;
    localparam int RB_PEN   = 4;

    // Fallback value of shadow byte idx
    function automatic logic [7:0] dflt_byte(input int idx);
        logic [31:0] v;
        v = 32'(idx * 7 + 3);
        return v[7:0];
    endfunction

endpackage

// File: rtl/eecfg_mw_rd.sv
module eecfg_mw_rd #(
    parameter int AW      = 6,
    parameter int SK_HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          ee_do,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    output logic          done,
    output logic          no_dev,
    output logic [15:0]   word
);
    import eecfg_pkg::*;

    localparam int CMD_BITS  = 3 + AW;
    localparam int DUMMY_IDX = CMD_BITS;
    localparam int LAST_IDX  = CMD_BITS + 16;
    localparam int CW        = $clog2(LAST_IDX + 1);
    localparam int DW        = $clog2(SK_HALF + 1);

    mw_state_t st, st_nx;
    logic [DW-1:0]       div;
    logic [CW-1:0]       bitn;
    logic [CMD_BITS-1:0] cmd;
    logic                ph;
    logic                tick;

    assign tick = (div == DW'(SK_HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            E_IDLE:  if (start) st_nx = E_SHIFT;
            E_SHIFT: begin
                if (tick && !ph && bitn == CW'(DUMMY_IDX) && ee_do)
                    st_nx = E_GAP;
                else if (tick && ph && bitn == CW'(LAST_IDX))
                    st_nx = E_GAP;
            end
            E_GAP:   if (tick && ph) st_nx = E_IDLE;
            default: st_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div    <= '0;
            ph     <= 1'b0;
            bitn   <= '0;
            cmd    <= '0;
            word   <= '0;
            no_dev <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                E_IDLE: begin
                    div  <= '0;
                    ph   <= 1'b0;
                    bitn <= '0;
                    if (start) begin
                        cmd    <= {3'b110, addr};
                        no_dev <= 1'b0;
                    end
                end
                E_SHIFT: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) begin
                        if (!ph) begin
                            if (bitn == CW'(DUMMY_IDX) && ee_do) begin
                                no_dev <= 1'b1;
                            end else begin
                                ph <= 1'b1;
                                if (bitn > CW'(DUMMY_IDX))
                                    word <= {word[14:0], ee_do};
                            end
                        end else begin
                            ph   <= 1'b0;
                            bitn <= bitn + 1'b1;
                            cmd  <= {cmd[CMD_BITS-2:0], 1'b0};
                        end
                    end
                end
                E_GAP: begin
                    div <= tick ? '0 : div + 1'b1;
                    if (tick) ph <= ~ph;
                    if (tick && ph) done <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ee_cs = (st == E_SHIFT);
        ee_sk = (st == E_SHIFT) && ph;
        ee_di = (st == E_SHIFT) && (bitn < CW'(CMD_BITS)) && cmd[CMD_BITS-1];
    end

    // R1: data to the device holds while the serial clock stays high
    a_r1_di_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R6: an absent device leaves the select line released
    a_r6_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        no_dev |-> !ee_cs);

endmodule

// File: rtl/eecfg_shadow.sv
module eecfg_shadow #(
    parameter int         N_BYTES = 36,
    parameter logic [7:0] CSUM    = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_sum,
    input  logic                   wr_en,
    input  logic [$clog2(N_BYTES/2)-1:0] wr_idx,
    input  logic [15:0]            wr_word,
    input  logic                   commit,
    input  logic                   keep,
    output logic [N_BYTES*8-1:0]   cfg,
    output logic                   sum_ok
);
    import eecfg_pkg::*;

    localparam int NW = N_BYTES / 2;
    localparam int IW = $clog2(NW);

    logic [7:0] sum;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_sum) sum <= '0;
        else if (wr_en)        sum <= sum + wr_word[15:8] + wr_word[7:0];
    end

    assign sum_ok = (sum == CSUM);

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [15:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n || (commit && !keep))
                q <= {dflt_byte(2 * w), dflt_byte(2 * w + 1)};
            else if (wr_en && wr_idx == IW'(w))
                q <= wr_word;
        end
        assign cfg[2*w*8 +: 8]     = q[15:8];
        assign cfg[(2*w+1)*8 +: 8] = q[7:0];
    end

    // R5: a rejected load restores the fallback bytes
    a_r5_defaults_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !keep) |=> (cfg[7:0] == dflt_byte(0)
                               && cfg[N_BYTES*8-1 -: 8] == dflt_byte(N_BYTES - 1)));

endmodule

// File: rtl/eecfg_loader.sv
module eecfg_loader #(
    parameter int         N_BYTES = 36,
    parameter int         AW      = 6,
    parameter int         SK_HALF = 2,
    parameter logic [7:0] CSUM    = 8'hFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 det_strap,
    input  logic                 stop,
    input  logic                 hst_we,
    input  logic                 hst_re,
    input  logic [15:0]          hst_wdata,
    output logic [15:0]          hst_rdata,
    output logic                 hst_ack,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    input  logic                 ee_do,
    output logic                 busy_o,
    output logic                 swcfg_wait,
    output logic [N_BYTES*8-1:0] cfg_data
);
    import eecfg_pkg::*;

    localparam int NW = N_BYTES / 2;
    localparam int IW = $clog2(NW);

    ld_state_t st, st_nx;
    logic [IW-1:0] widx;
    logic          load_req, valid, det_q, pen;
    logic [3:0]    swb;
    logic          host_ok;
    logic [15:0]   stat;
    logic          mw_cs, mw_sk, mw_di, mw_done, mw_absent;
    logic [15:0]   mw_word;
    logic          sum_ok, wr_en, commit, keep, clr_sum;

    eecfg_mw_rd #(.AW(AW), .SK_HALF(SK_HALF)) u_mw (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (st == ST_START),
        .addr   (AW'(widx)),
        .ee_do  (ee_do),
        .ee_cs  (mw_cs),
        .ee_sk  (mw_sk),
        .ee_di  (mw_di),
        .done   (mw_done),
        .no_dev (mw_absent),
        .word   (mw_word)
    );

    assign wr_en   = (st == ST_WAIT) && mw_done && !mw_absent;
    assign commit  = (st == ST_DONE) || (st == ST_FAIL);
    assign keep    = (st == ST_DONE) && sum_ok;
    assign clr_sum = (st == ST_IDLE) || (st == ST_BOOT);

    eecfg_shadow #(.N_BYTES(N_BYTES), .CSUM(CSUM)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_sum (clr_sum),
        .wr_en   (wr_en),
        .wr_idx  (widx),
        .wr_word (mw_word),
        .commit  (commit),
        .keep    (keep),
        .cfg     (cfg_data),
        .sum_ok  (sum_ok)
    );

    assign host_ok = (hst_we || hst_re) && (st == ST_IDLE) && !load_req;
    assign stat    = {valid, load_req, det_q, 8'h00, pen, swb};

    // Strap capture: follows the pin only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= det_strap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_BOOT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_BOOT:  st_nx = det_q ? ST_START : ST_IDLE;
            ST_IDLE:  if (load_req) st_nx = ST_START;
            ST_START: st_nx = ST_WAIT;
            ST_WAIT: begin
                if (mw_done) begin
                    if (mw_absent)                st_nx = ST_FAIL;
                    else if (widx == IW'(NW - 1)) st_nx = ST_DONE;
                    else                          st_nx = ST_START;
                end
            end
            ST_DONE:  st_nx = ST_IDLE;
            ST_FAIL:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx       <= '0;
            load_req   <= 1'b0;
            valid      <= 1'b0;
            pen        <= 1'b0;
            swb        <= '0;
            swcfg_wait <= 1'b0;
            hst_ack    <= 1'b0;
            hst_rdata  <= '0;
        end else begin
            hst_ack <= host_ok;
            if (host_ok && hst_re) hst_rdata <= stat;
            if (host_ok && hst_we) begin
                pen <= hst_wdata[RB_PEN];
                swb <= hst_wdata[3:0];
                if (stop && hst_wdata[RB_REQ]) load_req <= 1'b1;
            end
            unique case (st)
                ST_BOOT: begin
                    widx       <= '0;
                    load_req   <= det_q;
                    swcfg_wait <= !det_q;
                end
                ST_IDLE: begin
                    widx <= '0;
                    if (load_req) valid <= 1'b0;
                end
                ST_WAIT: if (mw_done && !mw_absent) widx <= widx + 1'b1;
                ST_DONE: begin
                    load_req   <= 1'b0;
                    valid      <= sum_ok;
                    swcfg_wait <= !sum_ok;
                end
                ST_FAIL: begin
                    load_req   <= 1'b0;
                    valid      <= 1'b0;
                    swcfg_wait <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (load_req) begin
            ee_cs = mw_cs;
            ee_sk = mw_sk;
            ee_di = mw_di;
        end else if (pen) begin
            ee_cs = swb[2];
            ee_sk = swb[1];
            ee_di = swb[0];
        end else begin
            ee_cs = 1'b0;
            ee_sk = 1'b0;
            ee_di = 1'b0;
        end
        busy_o = (!load_req && pen) ? swb[3] : !valid;
    end

    // R2: no acknowledge for an access made while a load was pending
    a_r2_no_ack_loading: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_req) |-> !hst_ack);

    // R3: the request bit falls only when a load finishes
    a_r3_req_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_req) |-> ($past(st) == ST_DONE || $past(st) == ST_FAIL));

    // R4: valid rises only after a matching checksum
    a_r4_valid_needs_sum: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(sum_ok));

    // R7: the captured strap never moves outside reset
    a_r7_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(det_q));

    // R9: a request appears only from the boot load or a write under stop
    a_r9_req_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_req) |-> ($past(stop) || $past(st) == ST_BOOT));

    // R11: serial pins rest low with no load and pin-enable clear
    a_r11_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !pen) |-> (!ee_cs && !ee_sk && !ee_di));

endmodule

// File: tb/test_eecfg_loader.sv
module test_eecfg_loader;

    localparam int         N_BYTES = 36;
    localparam int         AW      = 6;
    localparam int         SK_HALF = 1;
    localparam logic [7:0] CSUM    = 8'hFF;
    localparam int         NW      = N_BYTES / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_strap = 1'b0;
    logic stop = 1'b0;
    logic hst_we = 1'b0, hst_re = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic hst_ack, ee_cs, ee_sk, ee_di, ee_do, busy_o, swcfg_wait;
    logic [N_BYTES*8-1:0] cfg_data;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    eecfg_loader #(.N_BYTES(N_BYTES), .AW(AW), .SK_HALF(SK_HALF), .CSUM(CSUM)) i_eecfg_loader (
        .clk(clk), .rst_n(rst_n), .det_strap(det_strap), .stop(stop),
        .hst_we(hst_we), .hst_re(hst_re), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_ack(hst_ack),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .busy_o(busy_o), .swcfg_wait(swcfg_wait), .cfg_data(cfg_data)
    );

    // ---------------- serial device model ----------------
    logic [15:0] mem [64];
    logic        present = 1'b1;
    int          m_cnt = 0;
    int          m_frames = 0;
    logic [8:0]  m_shin = '0;
    logic        m_sk_q = 1'b0, m_cs_q = 1'b0;
    logic [8:0]  m_frame [1024];

    always @(negedge clk) begin
        m_sk_q <= ee_sk;
        m_cs_q <= ee_cs;
        if (!ee_cs) begin
            if (m_cs_q) begin
                m_frame[m_frames] <= m_shin;
                m_frames <= m_frames + 1;
            end
            m_cnt <= 0;
        end else if (ee_sk && !m_sk_q) begin
            if (m_cnt < 9) m_shin <= {m_shin[7:0], ee_di};
            m_cnt <= m_cnt + 1;
        end
    end

    always_comb begin
        if (!present || !ee_cs || m_cnt < 9) ee_do = 1'b1;
        else if (m_cnt == 9)                 ee_do = 1'b0;
        else if (m_cnt <= 25)                ee_do = mem[m_shin[5:0]][25 - m_cnt];
        else                                 ee_do = 1'b1;
    end

    // ---------------- expected-value functions ----------------
    function automatic logic [N_BYTES*8-1:0] exp_dflt();
        logic [N_BYTES*8-1:0] v;
        for (int i = 0; i < N_BYTES; i++) v[i*8 +: 8] = 8'((7 * i + 3) % 256);
        return v;
    endfunction

    function automatic logic [N_BYTES*8-1:0] exp_loaded();
        logic [N_BYTES*8-1:0] v;
        for (int w = 0; w < NW; w++) begin
            v[2*w*8 +: 8]     = mem[w][15:8];
            v[(2*w+1)*8 +: 8] = mem[w][7:0];
        end
        return v;
    endfunction

    function automatic logic [7:0] sum8();
        logic [7:0] s = 8'h00;
        for (int w = 0; w < NW; w++) s = s + mem[w][15:8] + mem[w][7:0];
        return s;
    endfunction

    function automatic logic [15:0] stat(input logic v, input logic r, input logic d,
                                         input logic [4:0] lo);
        return {v, r, d, 8'h00, lo};
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_cfg(input string tag, input logic [N_BYTES*8-1:0] exp);
        vectors++;
        if (cfg_data !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, cfg_data, exp);
        end
    endtask

    task automatic chk_frames(input string tag, input int f0, input int n);
        logic ok = 1'b1;
        chk({tag, " frame count"}, 32'(m_frames - f0), 32'(n));
        for (int k = 0; k < n && f0 + k < m_frames; k++)
            if (m_frame[f0 + k] !== {3'b110, 6'(k)}) ok = 1'b0;
        chk({tag, " frame bits"}, {31'd0, ok}, 32'd1);
    endtask

    task automatic host(input logic we, input logic re, input logic [15:0] wd,
                        output logic ack, output logic [15:0] rd);
        @(negedge clk);
        hst_we = we; hst_re = re; hst_wdata = wd;
        @(negedge clk);
        hst_we = 1'b0; hst_re = 1'b0;
        ack = hst_ack; rd = hst_rdata;
    endtask

    task automatic wait_idle(output logic [15:0] s);
        logic a;
        logic [15:0] d;
        s = 16'hDEAD;
        for (int i = 0; i < 20000; i++) begin
            host(1'b0, 1'b1, 16'h0000, a, d);
            if (a) begin
                s = d;
                return;
            end
        end
    endtask

    task automatic do_reset(input logic det);
        @(negedge clk);
        rst_n = 1'b0;
        det_strap = det;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill_mem(input int mode);
        for (int w = 0; w < 64; w++) mem[w] = 16'($urandom);
        if (mode != 2) begin
            mem[NW-1][7:0] = 8'h00;
            mem[NW-1][7:0] = CSUM - sum8();
        end
        if (mode == 1) mem[3][0] = ~mem[3][0];
    endtask

    // host-requested load; also probes that an access made mid-load is dropped (R2)
    task automatic run_load(output logic [15:0] s);
        logic a;
        logic [15:0] d;
        host(1'b1, 1'b0, 16'h4000, a, d);
        host(1'b1, 1'b0, 16'h001F, a, d);
        chk("R2 write during load not acknowledged", {31'd0, a}, 32'd0);
        wait_idle(s);
    endtask

    initial begin
        logic a;
        logic [15:0] d, s;
        int f0, seed;
        logic ev;
        seed = $urandom(32'd20240611);
        for (int w = 0; w < 64; w++) mem[w] = 16'h0000;

        // ---- reset with strap low ----
        do_reset(1'b0);
        f0 = m_frames;
        repeat (100) @(negedge clk);
        chk("R8 no frame without strap", 32'(m_frames - f0), 32'd0);
        chk("R8 software wait after strap-low reset", {31'd0, swcfg_wait}, 32'd1);
        wait_idle(s);
        chk("R13 reset status", {16'd0, s}, {16'd0, stat(1'b0, 1'b0, 1'b0, 5'h00)});
        chk_cfg("R13 reset shadow defaults", exp_dflt());
        chk("R11 busy shows inverted valid", {31'd0, busy_o}, 32'd1);
        chk("R11 pins quiet", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);

        // ---- reserved bits and stop gating ----
        host(1'b1, 1'b0, 16'hFFFF, a, d);
        chk("R9 write with stop low acknowledged", {31'd0, a}, 32'd1);
        repeat (20) @(negedge clk);
        wait_idle(s);
        chk("R12 R9 status after all-ones write", {16'd0, s},
            {16'd0, stat(1'b0, 1'b0, 1'b0, 5'h1F)});
        chk("R9 no frame with stop low", 32'(m_frames - f0), 32'd0);
        chk("R10 pins follow software bits", {28'd0, busy_o, ee_cs, ee_sk, ee_di}, 32'hF);
        host(1'b1, 1'b0, 16'h0015, a, d);
        chk("R10 pins follow pattern 0101", {28'd0, busy_o, ee_cs, ee_sk, ee_di}, 32'h5);
        host(1'b1, 1'b0, 16'h000A, a, d);
        chk("R10 pins idle with enable clear", {28'd0, busy_o, ee_cs, ee_sk, ee_di}, 32'h8);

        // ---- good load, strap low (R9: attempted regardless of strap) ----
        stop = 1'b1;
        host(1'b1, 1'b0, 16'h0000, a, d);
        fill_mem(0);
        f0 = m_frames;
        run_load(s);
        chk("R4 R3 R2 status after good load", {16'd0, s}, {16'd0, stat(1'b1, 1'b0, 1'b0, 5'h00)});
        chk_cfg("R4 R1 shadow holds loaded bytes", exp_loaded());
        chk_frames("R1 good load", f0, NW);
        chk("R11 busy low when valid", {31'd0, busy_o}, 32'd0);
        chk("R4 software wait cleared", {31'd0, swcfg_wait}, 32'd0);

        // ---- checksum miss ----
        fill_mem(1);
        f0 = m_frames;
        run_load(s);
        chk("R5 R3 status after checksum miss", {16'd0, s}, {16'd0, stat(1'b0, 1'b0, 1'b0, 5'h00)});
        chk_cfg("R5 shadow defaults after miss", exp_dflt());
        chk_frames("R1 miss load", f0, NW);

        // ---- random loads ----
        for (int it = 0; it < 12; it++) begin
            fill_mem(int'($urandom % 3));
            ev = (sum8() == CSUM);
            f0 = m_frames;
            run_load(s);
            chk("R4 R5 random load status", {16'd0, s}, {16'd0, stat(ev, 1'b0, 1'b0, 5'h00)});
            chk_cfg("R4 R5 random load shadow", ev ? exp_loaded() : exp_dflt());
            chk_frames("R1 random load", f0, NW);
        end

        // ---- absent device after a good load ----
        fill_mem(0);
        run_load(s);
        chk("R4 valid before absent test", {16'd0, s}, {16'd0, stat(1'b1, 1'b0, 1'b0, 5'h00)});
        present = 1'b0;
        f0 = m_frames;
        run_load(s);
        chk("R6 R3 status with no device", {16'd0, s}, {16'd0, stat(1'b0, 1'b0, 1'b0, 5'h00)});
        chk("R6 single truncated frame", 32'(m_frames - f0), 32'd1);
        chk_cfg("R6 shadow back to defaults", exp_dflt());
        chk("R6 software wait set", {31'd0, swcfg_wait}, 32'd1);
        present = 1'b1;

        // ---- strap high, device present: boot load ----
        stop = 1'b0;
        fill_mem(0);
        f0 = m_frames;
        do_reset(1'b1);
        det_strap = 1'b0;
        wait_idle(s);
        chk("R8 R7 boot load status", {16'd0, s}, {16'd0, stat(1'b1, 1'b0, 1'b1, 5'h00)});
        chk_cfg("R8 boot load shadow", exp_loaded());
        chk_frames("R1 boot load", f0, NW);
        det_strap = 1'b1;
        repeat (5) @(negedge clk);
        det_strap = 1'b0;
        wait_idle(s);
        chk("R7 strap bit unchanged by pin", {16'd0, s}, {16'd0, stat(1'b1, 1'b0, 1'b1, 5'h00)});

        // ---- strap high, no device: boot load aborts ----
        present = 1'b0;
        f0 = m_frames;
        do_reset(1'b1);
        wait_idle(s);
        chk("R6 R8 aborted boot status", {16'd0, s}, {16'd0, stat(1'b0, 1'b0, 1'b1, 5'h00)});
        chk("R6 aborted boot single frame", 32'(m_frames - f0), 32'd1);
        chk("R6 aborted boot software wait", {31'd0, swcfg_wait}, 32'd1);
        chk_cfg("R6 aborted boot defaults", exp_dflt());

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule